// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block receives 25-bit control words from a host over a three-wire serial link made of a serial clock, a data line and a strobe. While the strobe is low, each rising edge of the serial clock shifts one data bit into a word register, most significant bit first. While the strobe is high the word register is frozen. On the rising edge of the strobe, the block checks the word that was collected. A word with a valid header and a defined group code is copied into exactly one of five holding registers: the main divider, the reference divider, the auto-tuning divider, the amplifier gain step and the system control register. Any other word is discarded and flagged as an error.

All three serial pins and the battery-save pin pass through two-flop synchronisers into the system clock domain. The serial clock and the strobe are then edge-detected. From the system control register the block derives several outputs: a one-hot charge-pump current select, a one-hot comparator resistor select, the modulator enable with its gated transmit-data drive, and the four modulation mode bits. The battery-save pin and three power-down bits together give enable lines for the receive chain, the power amplifier, the transmit filter, the synthesiser and the auto-tuning loop.

Top module: `tw_ctl_port`

## Requirements
- R1: After reset, every holding register is zero, the error flag is low and all enables are off. Once the battery-save pin is sampled high with the reset-time power bits (000), the receive, synthesiser and auto-tune enables are on, and the amplifier and transmit-filter enables are off.
- R2: Data is shifted in MSB first on each serial clock rising edge. The word layout from bit 24 down to bit 0 is: header in bits 24:21 (must be 1010), group code in bits 20:16, payload in bits 15:0. A group code of 0 loads the main divider, with N in payload bits 15:7 and A in bits 6:1.
- R3: While the strobe is high, serial clock edges do not change the collected word. A strobe rising edge with no new bits clocked in therefore commits the previously collected word again.
- R4: Each valid word changes only the register that its group code selects. The other four registers keep their values.
- R5: Group code 1 loads the reference divider from payload bits 15:7. Group code 2 loads the auto-tuning divider from payload bits 15:8.
- R6: Group code 3 loads the amplifier gain step from payload bits 15:11.
- R7: A word whose header is not 1010, or whose group code is above 4, changes no register and sets the error flag. The next valid word clears the flag.
- R8: Group code 4 loads system control. Payload bits 15:14 hold the charge-pump code, which maps to cp_sel (bit 2 = 4 mA, bit 1 = 2 mA, bit 0 = 1 mA) as follows: 00 gives 4 mA, 01 gives 2 mA, and both 10 and 11 give 1 mA.
- R9: System payload bits 5:4 hold the comparator resistor code, which maps to cmp_res_sel (bit 0 = 10 k, bit 1 = 100 k, bit 2 = 1000 k) as follows: 00 and 01 give 10 k, 10 gives 100 k, 11 gives 1000 k.
- R10: System payload bit 13 is the modulator enable. When it is 0, mod_drive stays 0 whatever tx_bit is. When it is 1, mod_drive follows tx_bit. Payload bits 9:6 appear on mod_mode[3:0].
- R11: System payload bits 12:10 are the power bits, written in the order bits 12:10 = third, second, first. When the battery-save pin is low, all enables are off. When it is high, the power bits decode as follows: 000 turns on receive, synthesiser and auto-tune; 001 turns on transmit filter, synthesiser and auto-tune; 101 turns on amplifier, transmit filter, synthesiser and auto-tune; 100 turns on synthesiser and auto-tune; 011 turns on auto-tune only; 111 turns everything off.
- R12: The undefined power codes 010 and 110 turn every enable off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_stb | input | 1 | Strobe: low to shift, rising edge to commit |
| bs_pin | input | 1 | Battery-save pin, high allows operation |
| tx_bit | input | 1 | Transmit data to be gated by the modulator enable |
| div_n | output | 9 | Main divider N count |
| div_a | output | 6 | Main divider A count |
| div_ref | output | 9 | Reference divider |
| div_tune | output | 8 | Auto-tuning divider |
| pa_step | output | 5 | Amplifier gain step |
| cp_sel | output | 3 | One-hot charge-pump current select |
| mod_en | output | 1 | Modulator enable |
| mod_mode | output | 4 | Modulation mode bits |
| mod_drive | output | 1 | Gated transmit data |
| cmp_res_sel | output | 3 | One-hot comparator resistor select |
| en_rx | output | 1 | Receive chain enable |
| en_pa | output | 1 | Power amplifier enable |
| en_txf | output | 1 | Transmit filter enable |
| en_pll | output | 1 | Synthesiser enable |
| en_tune | output | 1 | Auto-tuning enable |
| word_err | output | 1 | Last committed word was rejected |

## Verification
A strobe rising edge reaches the holding registers three system clock edges later: two synchroniser stages, then the edge-detected load. Derived outputs follow on the same edge through combinational decode. A change on the battery-save pin reaches the enables after two edges, and tx_bit reaches mod_drive with no clock at all. The bench holds each serial level for four system clocks and waits eight clocks after every strobe edge or pin change before sampling on a falling clock edge. Every check therefore lands well after its result is due and well before the next stimulus.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int HDR_W   = 4;
   localparam logic [HDR_W-1:0] HDR_KEY = 4'b1010;
   localparam int GC_W    = 5;
   localparam int PAY_W   = 16;
   localparam int WORD_W  = HDR_W + GC_W + PAY_W;
   localparam int N_W     = 9;
   localparam int A_W     = 6;
   localparam int R_W     = 9;
   localparam int F_W     = 8;
   localparam int P_W     = 5;

   typedef enum logic [GC_W-1:0] {
      GC_MAIN = 5'd0,
      GC_REF  = 5'd1,
      GC_TUNE = 5'd2,
      GC_GAIN = 5'd3,
      GC_SYS  = 5'd4
   } grp_e;

   typedef struct packed {
      logic [1:0] cp;
      logic       mod;
      logic [2:0] pd;
      logic [3:0] mm;
      logic [1:0] dc;
   } sys_t;

   localparam int SYS_W = $bits(sys_t);

   typedef struct packed {
      logic rx;
      logic pa;
      logic txf;
      logic pll;
      logic tune;
   } pwr_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
   import tw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              stb_s,
   output logic [WORD_W-1:0] word,
   output logic              commit
);
   logic sclk_d, stb_d;
   logic [WORD_W-1:0] sh;
   logic shift_en;

   assign shift_en = sclk_s & ~sclk_d & ~stb_s;
   assign commit   = stb_s & ~stb_d;
   assign word     = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         stb_d  <= 1'b0;
         sh     <= '0;
      end else begin
         sclk_d <= sclk_s;
         stb_d  <= stb_s;
         if (shift_en) begin
            sh <= {sh[WORD_W-2:0], sdat_s};
         end
      end
   end

   // R3: word frozen while strobe is high
   p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_s |=> $stable(sh));
endmodule

// File: rtl/tw_regs.sv
module tw_regs
   import tw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [WORD_W-1:0] word,
   output logic [N_W-1:0]    main_n,
   output logic [A_W-1:0]    main_a,
   output logic [R_W-1:0]    ref_r,
   output logic [F_W-1:0]    tune_f,
   output logic [P_W-1:0]    gain_p,
   output sys_t              sys,
   output logic              word_err
);
   logic [HDR_W-1:0] hdr;
   logic [GC_W-1:0]  gc;
   logic [PAY_W-1:0] pay;
   logic             word_ok;
   logic             unused_low;

   if (N_W + A_W + 1 > PAY_W || SYS_W > PAY_W) begin : g_bad_layout
      $error("payload too narrow for its fields");
   end

   assign hdr     = word[WORD_W-1 -: HDR_W];
   assign gc      = word[PAY_W +: GC_W];
   assign pay     = word[PAY_W-1:0];
   assign word_ok = (hdr == HDR_KEY) && (gc <= GC_SYS);
   assign unused_low = ^pay[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_n   <= '0;
         main_a   <= '0;
         ref_r    <= '0;
         tune_f   <= '0;
         gain_p   <= '0;
         sys      <= '0;
         word_err <= 1'b0;
      end else if (commit) begin
         word_err <= !word_ok;
         if (word_ok) begin
            case (gc)
               GC_MAIN: begin
                  main_n <= pay[PAY_W-1 -: N_W];
                  main_a <= pay[PAY_W-1-N_W -: A_W];
               end
               GC_REF:  ref_r  <= pay[PAY_W-1 -: R_W];
               GC_TUNE: tune_f <= pay[PAY_W-1 -: F_W];
               GC_GAIN: gain_p <= pay[PAY_W-1 -: P_W];
               GC_SYS:  sys    <= sys_t'(pay[PAY_W-1 -: SYS_W]);
               default: ;
            endcase
         end
      end
   end

   // R7: a rejected word leaves every register alone and raises the flag
   p_bad_word_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !word_ok) |=> (word_err && $stable(main_n) && $stable(main_a)
         && $stable(ref_r) && $stable(tune_f) && $stable(gain_p) && $stable(sys)));

   // R4: a gain word touches no other register
   p_gain_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && word_ok && gc == GC_GAIN) |=> ($stable(main_n) && $stable(ref_r)
         && $stable(tune_f) && $stable(sys) && !word_err));
endmodule

// File: rtl/tw_derive.sv
module tw_derive
   import tw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sys_t       sys,
   input  logic       bs,
   input  logic       tx_bit,
   output logic [2:0] cp_sel,
   output logic [2:0] res_sel,
   output logic       mod_en,
   output logic [3:0] mod_mode,
   output logic       mod_drive,
   output pwr_t       pwr
);
   always_comb begin
      case (sys.cp)
         2'b00:   cp_sel = 3'b100;
         2'b01:   cp_sel = 3'b010;
         default: cp_sel = 3'b001;
      endcase
   end

   always_comb begin
      case (sys.dc)
         2'b10:   res_sel = 3'b010;
         2'b11:   res_sel = 3'b100;
         default: res_sel = 3'b001;
      endcase
   end

   assign mod_en    = sys.mod;
   assign mod_mode  = sys.mm;
   assign mod_drive = sys.mod & tx_bit;

   always_comb begin
      pwr = '0;
      if (bs) begin
         case (sys.pd)
            3'b000: pwr = '{rx: 1'b1, pa: 1'b0, txf: 1'b0, pll: 1'b1, tune: 1'b1};
            3'b001: pwr = '{rx: 1'b0, pa: 1'b0, txf: 1'b1, pll: 1'b1, tune: 1'b1};
            3'b101: pwr = '{rx: 1'b0, pa: 1'b1, txf: 1'b1, pll: 1'b1, tune: 1'b1};
            3'b100: pwr = '{rx: 1'b0, pa: 1'b0, txf: 1'b0, pll: 1'b1, tune: 1'b1};
            3'b011: pwr = '{rx: 1'b0, pa: 1'b0, txf: 1'b0, pll: 1'b0, tune: 1'b1};
            default: pwr = '0;
         endcase
      end
   end

   // R8: exactly one current selected
   p_cp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cp_sel) == 1);
   // R9: exactly one resistor selected
   p_res_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(res_sel) == 1);
   // R10: no drive without the modulator enable
   p_mod_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |-> !mod_drive);
   // R11: amplifier only with filter, synthesiser and tuning
   p_pa_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr.pa |-> (pwr.txf && pwr.pll && pwr.tune && !pwr.rx));
   // R11: battery-save low forces everything off
   p_bs_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bs |-> (pwr == '0));
endmodule

// File: rtl/tw_ctl_port.sv
module tw_ctl_port
   import tw_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_clk,
   input  logic           ser_dat,
   input  logic           ser_stb,
   input  logic           bs_pin,
   input  logic           tx_bit,
   output logic [N_W-1:0] div_n,
   output logic [A_W-1:0] div_a,
   output logic [R_W-1:0] div_ref,
   output logic [F_W-1:0] div_tune,
   output logic [P_W-1:0] pa_step,
   output logic [2:0]     cp_sel,
   output logic           mod_en,
   output logic [3:0]     mod_mode,
   output logic           mod_drive,
   output logic [2:0]     cmp_res_sel,
   output logic           en_rx,
   output logic           en_pa,
   output logic           en_txf,
   output logic           en_pll,
   output logic           en_tune,
   output logic           word_err
);
   localparam int PIN_W = 4;

   if (WORD_W != 25) begin : g_bad_word
      $error("control word must be 25 bits");
   end

   logic [PIN_W-1:0] pins_s;
   logic [WORD_W-1:0] word;
   logic commit;
   sys_t sys;
   pwr_t pwr;

   tw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bs_pin, ser_stb, ser_dat, ser_clk}),
      .q     (pins_s)
   );

   tw_shift u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (pins_s[0]),
      .sdat_s (pins_s[1]),
      .stb_s  (pins_s[2]),
      .word   (word),
      .commit (commit)
   );

   tw_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .word     (word),
      .main_n   (div_n),
      .main_a   (div_a),
      .ref_r    (div_ref),
      .tune_f   (div_tune),
      .gain_p   (pa_step),
      .sys      (sys),
      .word_err (word_err)
   );

   tw_derive u_derive (
      .clk       (clk),
      .rst_n     (rst_n),
      .sys       (sys),
      .bs        (pins_s[3]),
      .tx_bit    (tx_bit),
      .cp_sel    (cp_sel),
      .res_sel   (cmp_res_sel),
      .mod_en    (mod_en),
      .mod_mode  (mod_mode),
      .mod_drive (mod_drive),
      .pwr       (pwr)
   );

   assign en_rx   = pwr.rx;
   assign en_pa   = pwr.pa;
   assign en_txf  = pwr.txf;
   assign en_pll  = pwr.pll;
   assign en_tune = pwr.tune;
endmodule

// File: tb/test_tw_ctl_port.sv
module test_tw_ctl_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0, bs_pin = 1'b0, tx_bit = 1'b0;
   logic [8:0] div_n, div_ref;
   logic [5:0] div_a;
   logic [7:0] div_tune;
   logic [4:0] pa_step;
   logic [2:0] cp_sel, cmp_res_sel;
   logic [3:0] mod_mode;
   logic mod_en, mod_drive, en_rx, en_pa, en_txf, en_pll, en_tune, word_err;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   tw_ctl_port i_tw_ctl_port (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_stb(ser_stb), .bs_pin(bs_pin), .tx_bit(tx_bit),
      .div_n(div_n), .div_a(div_a), .div_ref(div_ref), .div_tune(div_tune),
      .pa_step(pa_step), .cp_sel(cp_sel), .mod_en(mod_en), .mod_mode(mod_mode),
      .mod_drive(mod_drive), .cmp_res_sel(cmp_res_sel), .en_rx(en_rx),
      .en_pa(en_pa), .en_txf(en_txf), .en_pll(en_pll), .en_tune(en_tune),
      .word_err(word_err)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [24:0] mk(logic [4:0] gc, logic [15:0] pay);
      return {4'b1010, gc, pay};
   endfunction

   function automatic logic [24:0] sysw(logic [1:0] cp, logic md, logic [2:0] pd,
                                        logic [3:0] mm, logic [1:0] dc);
      return mk(5'd4, {cp, md, pd, mm, dc, 4'b0000});
   endfunction

   task automatic shift_bits(logic [24:0] w);
      for (int i = 24; i >= 0; i--) begin
         ser_dat = w[i];
         wait_clk(4);
         ser_clk = 1'b1;
         wait_clk(4);
         ser_clk = 1'b0;
      end
   endtask

   task automatic send(logic [24:0] w);
      ser_stb = 1'b0;
      wait_clk(4);
      shift_bits(w);
      wait_clk(4);
      ser_stb = 1'b1;
      wait_clk(8);
   endtask

   function automatic logic [4:0] pwr_exp(logic bs, logic [2:0] pd);
      if (!bs) return 5'b00000;
      case (pd)
         3'b000: return 5'b10011;
         3'b001: return 5'b00111;
         3'b101: return 5'b01111;
         3'b100: return 5'b00011;
         3'b011: return 5'b00001;
         default: return 5'b00000;
      endcase
   endfunction

   task automatic t_reset;
      check("R1 div_n", div_n, 0);
      check("R1 div_a", div_a, 0);
      check("R1 div_ref", div_ref, 0);
      check("R1 div_tune", div_tune, 0);
      check("R1 pa_step", pa_step, 0);
      check("R1 word_err", word_err, 0);
      check("R1 enables off", {en_rx, en_pa, en_txf, en_pll, en_tune}, 5'b00000);
      check("R1 cp 4mA", cp_sel, 3'b100);
      bs_pin = 1'b1;
      wait_clk(8);
      check("R1 receive default", {en_rx, en_pa, en_txf, en_pll, en_tune}, 5'b10011);
   endtask

   task automatic t_main;
      send(mk(5'd0, {9'h1A5, 6'h2B, 1'b0}));
      check("R2 div_n", div_n, 9'h1A5);
      check("R2 div_a", div_a, 6'h2B);
      send(mk(5'd0, {9'h100, 6'h01, 1'b0}));
      check("R2 div_n msb", div_n, 9'h100);
      check("R2 div_a lsb", div_a, 6'h01);
   endtask

   task automatic t_others;
      send(mk(5'd1, {9'h0F3, 7'd0}));
      check("R5 div_ref", div_ref, 9'h0F3);
      send(mk(5'd2, {8'hC8, 8'd0}));
      check("R5 div_tune", div_tune, 8'hC8);
      send(mk(5'd3, {5'd21, 11'd0}));
      check("R6 pa_step", pa_step, 5'd21);
      check("R4 div_n kept", div_n, 9'h100);
      check("R4 div_ref kept", div_ref, 9'h0F3);
      check("R4 div_tune kept", div_tune, 8'hC8);
      check("R4 cp kept", cp_sel, 3'b100);
   endtask

   task automatic t_bad;
      send({4'b1011, 5'd3, 5'd7, 11'd0});
      check("R7 bad header gain kept", pa_step, 5'd21);
      check("R7 bad header flag", word_err, 1);
      send(mk(5'd5, {5'd7, 11'd0}));
      check("R7 bad group gain kept", pa_step, 5'd21);
      check("R7 bad group div_n kept", div_n, 9'h100);
      check("R7 bad group flag", word_err, 1);
      send(mk(5'd3, {5'd2, 11'd0}));
      check("R7 flag cleared", word_err, 0);
      check("R7 gain after good", pa_step, 5'd2);
   endtask

   task automatic t_freeze;
      send(mk(5'd3, {5'd5, 11'd0}));
      check("R3 gain set", pa_step, 5'd5);
      shift_bits(mk(5'd3, {5'd9, 11'd0}));
      wait_clk(4);
      ser_stb = 1'b0;
      wait_clk(8);
      ser_stb = 1'b1;
      wait_clk(8);
      check("R3 frozen word recommitted", pa_step, 5'd5);
      check("R3 no error", word_err, 0);
   endtask

   task automatic t_cp;
      for (int c = 0; c < 4; c++) begin
         send(sysw(2'(c), 1'b0, 3'b000, 4'b0000, 2'b00));
         check("R8 cp_sel", cp_sel, (c == 0) ? 3'b100 : (c == 1) ? 3'b010 : 3'b001);
      end
   endtask

   task automatic t_res;
      for (int c = 0; c < 4; c++) begin
         send(sysw(2'b00, 1'b0, 3'b000, 4'b0000, 2'(c)));
         check("R9 cmp_res_sel", cmp_res_sel, (c < 2) ? 3'b001 : (c == 2) ? 3'b010 : 3'b100);
      end
   endtask

   task automatic t_mod;
      send(sysw(2'b00, 1'b0, 3'b000, 4'b0111, 2'b00));
      tx_bit = 1'b1;
      #1;
      check("R10 disabled drive", mod_drive, 0);
      check("R10 mod_en off", mod_en, 0);
      check("R10 mode bits", mod_mode, 4'b0111);
      send(sysw(2'b00, 1'b1, 3'b000, 4'b1000, 2'b00));
      check("R10 enabled drive high", mod_drive, 1);
      tx_bit = 1'b0;
      #1;
      check("R10 enabled drive low", mod_drive, 0);
      check("R10 mode bits 2", mod_mode, 4'b1000);
   endtask

   task automatic t_power;
      for (int p = 0; p < 8; p++) begin
         send(sysw(2'b00, 1'b0, 3'(p), 4'b0000, 2'b00));
         if (p == 2 || p == 6)
            check("R12 undefined power code", {en_rx, en_pa, en_txf, en_pll, en_tune},
                  pwr_exp(1'b1, 3'(p)));
         else
            check("R11 power decode", {en_rx, en_pa, en_txf, en_pll, en_tune},
                  pwr_exp(1'b1, 3'(p)));
      end
      send(sysw(2'b00, 1'b0, 3'b101, 4'b0000, 2'b00));
      bs_pin = 1'b0;
      wait_clk(8);
      check("R11 battery-save low", {en_rx, en_pa, en_txf, en_pll, en_tune}, 5'b00000);
      bs_pin = 1'b1;
      wait_clk(8);
      check("R11 transmit after wake", {en_rx, en_pa, en_txf, en_pll, en_tune}, 5'b01111);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_main();
      t_others();
      t_bad();
      t_freeze();
      t_cp();
      t_res();
      t_mod();
      t_power();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule